// File: doc/BRIEF.md
# Priority-Split FIFO Budget Controller

This block decides whether a DMA logical channel may become active. All active channels share one data FIFO. Each channel belongs to either the high-priority class or the low-priority class. An activating channel reserves its worst-case footprint, which is the per-channel depth limit plus one entry. The block grants the activation only if the class's total footprint, including the new channel, stays within that class's share of the FIFO. A two-bit split mode chooses how the FIFO is shared:

| Split mode | High-priority share | Low-priority share |
|---|---|---|
| 0 | one pool shared by both classes | one pool shared by both classes |
| 1 | one quarter | three quarters |
| 2 | three quarters | one quarter |
| 3 | one half | one half |

Each activation request also carries the channel's destination burst size. If that burst could never accumulate below the depth limit, the request is refused and a configuration error is flagged. Release requests give a class's reservation back. The FIFO storage and the transfer engine sit outside this block.

Activation requests, release requests and configuration writes are single-cycle strobes with no back-pressure. The block accepts each strobe in the cycle it is presented. It answers an activation one cycle later on the response pins. It also reports the live active count of each class.

Top module: `fbud_ctrl`

## Requirements
- R1: After reset, the depth limit reads 16 and the split mode reads 0. Both active counts read 0, and `rsp_valid` and `rel_err` are low.
- R2: A pulse on `cfg_wr` loads the split mode and the depth limit, and they take effect from the next cycle. A depth value of 0 is ignored, so the depth limit keeps its old value, but the mode is still loaded.
- R3: Each active channel is charged (depth limit + 1) entries. An activation is granted only if (active count of the budget pool after the request) × (depth limit + 1) is less than or equal to that pool's budget.
- R4: In split mode 0, the two classes are checked together. The high and low counts are summed, and the total is compared against `TOTAL_ENTRIES`.
- R5: In split mode 1, the high-priority budget is floor(T/4) and the low-priority budget is floor(3T/4), where T is `TOTAL_ENTRIES`.
- R6: In split mode 2, the high-priority budget is floor(3T/4) and the low-priority budget is floor(T/4).
- R7: In split mode 3, each class has a budget of floor(T/2).
- R8: An activation whose burst size is greater than or equal to the depth limit is denied. The response for that request has `rsp_burst_err` high, and the active counts do not change.
- R9: `rsp_valid`, `rsp_grant` and `rsp_burst_err` appear in the cycle after the activation strobe. A grant raises the requesting class's count by one in the same cycle.
- R10: A release lowers the named class's count by one. If that count is already 0, the release has no effect, and `rel_err` pulses high for one cycle in the next cycle.
- R11: When a release and an activation arrive in the same cycle, the release is applied first. The admission check sees the reduced counts.
- R12: A class never holds more than `MAX_CH` active channels. An activation for a class at that count is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode_in | input | 2 | Split mode to load |
| cfg_depth_in | input | DEPTH_W | Depth limit to load (0 ignored) |
| cfg_mode | output | 2 | Current split mode |
| cfg_depth | output | DEPTH_W | Current per-channel depth limit |
| act_valid | input | 1 | Activation request strobe |
| act_hi | input | 1 | Activation is for the high-priority class |
| act_burst | input | DEPTH_W | Destination burst size of the activating channel |
| rel_valid | input | 1 | Release request strobe |
| rel_hi | input | 1 | Release is for the high-priority class |
| rsp_valid | output | 1 | Activation response present |
| rsp_grant | output | 1 | Activation granted |
| rsp_burst_err | output | 1 | Activation refused because the burst is too large |
| rel_err | output | 1 | A release arrived for an empty class |
| hi_active | output | CNT_W | Active high-priority channels |
| lo_active | output | CNT_W | Active low-priority channels |

## Verification
The assertions assume the following about the inputs:
- Configuration inputs are stable across a clock edge whenever `cfg_wr` is high.
- Request strobes are never X while out of reset.
- `cfg_wr` is held low during reset, so the first post-reset comparison sees a defined history.

The stimulus changes every input only at the falling edge. It keeps all strobes driven to 0 or 1 from time zero. It draws the depth limit from a small range, sometimes 0, so that the budget boundary, the channel cap and the burst check are all reached many times in the random phase.

// File: rtl/fbud_pkg.sv
package fbud_pkg;

  typedef enum logic [1:0] {
    SPLIT_SHARED   = 2'd0,
    SPLIT_LO_MAJOR = 2'd1,
    SPLIT_HI_MAJOR = 2'd2,
    SPLIT_EVEN     = 2'd3
  } split_mode_e;

  localparam int CLS_LO = 0;
  localparam int CLS_HI = 1;
  localparam int N_CLS  = 2;

endpackage

// File: rtl/fbud_split_budget.sv
module fbud_split_budget
  import fbud_pkg::*;
#(
  parameter int TOTAL_ENTRIES = 256,
  parameter int BW            = $clog2(TOTAL_ENTRIES + 1)
) (
  input  split_mode_e   mode,
  output logic [BW-1:0] hi_budget,
  output logic [BW-1:0] lo_budget,
  output logic          pooled
);

  localparam int QUARTER   = TOTAL_ENTRIES / 4;
  localparam int THREE_QTR = (TOTAL_ENTRIES * 3) / 4;
  localparam int HALF      = TOTAL_ENTRIES / 2;

  always_comb begin
    pooled    = 1'b0;
    hi_budget = BW'(TOTAL_ENTRIES);
    lo_budget = BW'(TOTAL_ENTRIES);
    unique case (mode)
      SPLIT_SHARED: begin
        pooled = 1'b1;
      end
      SPLIT_LO_MAJOR: begin
        hi_budget = BW'(QUARTER);
        lo_budget = BW'(THREE_QTR);
      end
      SPLIT_HI_MAJOR: begin
        hi_budget = BW'(THREE_QTR);
        lo_budget = BW'(QUARTER);
      end
      SPLIT_EVEN: begin
        hi_budget = BW'(HALF);
        lo_budget = BW'(HALF);
      end
      default: pooled = 1'b1;
    endcase
  end

endmodule

// File: rtl/fbud_class_acct.sv
module fbud_class_acct #(
  parameter int MAX_CH = 32,
  parameter int CNT_W  = $clog2(MAX_CH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_after_rel,
  output logic             empty_rel
);

  logic has_any;

  assign has_any       = (cnt_q != '0);
  assign empty_rel     = dec && !has_any;
  assign cnt_after_rel = (dec && has_any) ? cnt_q - CNT_W'(1) : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_after_rel + CNT_W'(1);
    else cnt_q <= cnt_after_rel;
  end

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_CH));

  assert_no_inc_at_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && cnt_after_rel == CNT_W'(MAX_CH)));

  assert_inc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_dec_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_empty_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q == '0) |=> cnt_q == '0);

  assert_swap_keeps_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && inc && cnt_q != '0) |=> $stable(cnt_q));

endmodule

// File: rtl/fbud_admit.sv
module fbud_admit
  import fbud_pkg::*;
#(
  parameter int TOTAL_ENTRIES = 256,
  parameter int DEPTH_W       = 8,
  parameter int MAX_CH        = 32,
  parameter int CNT_W         = $clog2(MAX_CH + 1),
  parameter int BW            = $clog2(TOTAL_ENTRIES + 1)
) (
  input  logic               pooled,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               req_hi,
  input  logic [DEPTH_W-1:0] burst,
  input  logic [CNT_W-1:0]   hi_cnt,
  input  logic [CNT_W-1:0]   lo_cnt,
  input  logic [BW-1:0]      hi_budget,
  input  logic [BW-1:0]      lo_budget,
  output logic               allow,
  output logic               burst_bad
);

  localparam int NW = CNT_W + DEPTH_W + 2;
  localparam int CW = (NW > BW) ? NW : BW;

  logic [CW-1:0]    charge;
  logic [CW-1:0]    occupied;
  logic [CW-1:0]    need;
  logic [CW-1:0]    limit;
  logic [CNT_W-1:0] own_cnt;
  logic             class_full;
  logic             fits;

  always_comb begin
    own_cnt    = req_hi ? hi_cnt : lo_cnt;
    charge     = CW'(depth) + CW'(1);
    occupied   = pooled ? (CW'(hi_cnt) + CW'(lo_cnt)) : CW'(own_cnt);
    need       = (occupied + CW'(1)) * charge;
    limit      = pooled ? CW'(TOTAL_ENTRIES) : (req_hi ? CW'(hi_budget) : CW'(lo_budget));
    fits       = (need <= limit);
    class_full = (own_cnt == CNT_W'(MAX_CH));
    burst_bad  = (burst >= depth);
    allow      = !burst_bad && !class_full && fits;
  end

endmodule

// File: rtl/fbud_ctrl.sv
module fbud_ctrl
  import fbud_pkg::*;
#(
  parameter int TOTAL_ENTRIES = 256,
  parameter int DEPTH_W       = 8,
  parameter int MAX_CH        = 32,
  parameter int DEPTH_RESET   = 16,
  localparam int CNT_W        = $clog2(MAX_CH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_mode_in,
  input  logic [DEPTH_W-1:0] cfg_depth_in,
  output logic [1:0]         cfg_mode,
  output logic [DEPTH_W-1:0] cfg_depth,
  input  logic               act_valid,
  input  logic               act_hi,
  input  logic [DEPTH_W-1:0] act_burst,
  input  logic               rel_valid,
  input  logic               rel_hi,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic               rsp_burst_err,
  output logic               rel_err,
  output logic [CNT_W-1:0]   hi_active,
  output logic [CNT_W-1:0]   lo_active
);

  localparam int BW = $clog2(TOTAL_ENTRIES + 1);

  split_mode_e        mode_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [BW-1:0]      hi_budget;
  logic [BW-1:0]      lo_budget;
  logic               pooled;
  logic               allow;
  logic               burst_bad;

  logic [N_CLS-1:0]   inc_v;
  logic [N_CLS-1:0]   dec_v;
  logic [N_CLS-1:0]   empty_v;
  logic [CNT_W-1:0]   cnt_q   [N_CLS];
  logic [CNT_W-1:0]   cnt_rel [N_CLS];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= SPLIT_SHARED;
      depth_q <= DEPTH_W'(DEPTH_RESET);
    end else if (cfg_wr) begin
      mode_q <= split_mode_e'(cfg_mode_in);
      if (cfg_depth_in != '0) depth_q <= cfg_depth_in;
    end
  end

  assign cfg_mode  = mode_q;
  assign cfg_depth = depth_q;

  fbud_split_budget #(
    .TOTAL_ENTRIES(TOTAL_ENTRIES),
    .BW(BW)
  ) u_budget (
    .mode(mode_q),
    .hi_budget(hi_budget),
    .lo_budget(lo_budget),
    .pooled(pooled)
  );

  // per-class active counters
  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    localparam logic IS_HI = (c == CLS_HI);
    assign inc_v[c] = act_valid && allow && (act_hi == IS_HI);
    assign dec_v[c] = rel_valid && (rel_hi == IS_HI);
    fbud_class_acct #(
      .MAX_CH(MAX_CH),
      .CNT_W(CNT_W)
    ) u_acct (
      .clk(clk),
      .rst_n(rst_n),
      .inc(inc_v[c]),
      .dec(dec_v[c]),
      .cnt_q(cnt_q[c]),
      .cnt_after_rel(cnt_rel[c]),
      .empty_rel(empty_v[c])
    );
  end

  // admission sees counts after any same-cycle release
  fbud_admit #(
    .TOTAL_ENTRIES(TOTAL_ENTRIES),
    .DEPTH_W(DEPTH_W),
    .MAX_CH(MAX_CH),
    .CNT_W(CNT_W),
    .BW(BW)
  ) u_admit (
    .pooled(pooled),
    .depth(depth_q),
    .req_hi(act_hi),
    .burst(act_burst),
    .hi_cnt(cnt_rel[CLS_HI]),
    .lo_cnt(cnt_rel[CLS_LO]),
    .hi_budget(hi_budget),
    .lo_budget(lo_budget),
    .allow(allow),
    .burst_bad(burst_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_grant     <= 1'b0;
      rsp_burst_err <= 1'b0;
      rel_err       <= 1'b0;
    end else begin
      rsp_valid     <= act_valid;
      rsp_grant     <= act_valid && allow;
      rsp_burst_err <= act_valid && burst_bad;
      rel_err       <= |empty_v;
    end
  end

  assign hi_active = cnt_q[CLS_HI];
  assign lo_active = cnt_q[CLS_LO];

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(act_valid));

  assert_grant_has_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_valid);

  assert_burst_err_denies_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_burst_err |-> (rsp_valid && !rsp_grant));

  assert_burst_err_keeps_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && burst_bad && !rel_valid) |=> ($stable(hi_active) && $stable(lo_active)));

  assert_rel_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_valid));

  assert_depth_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_depth != '0);

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_mode == $past(cfg_mode_in));

  assert_one_grant_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inc_v) <= 1);

endmodule

// File: tb/tb_fbud_ctrl.sv
`timescale 1ns/1ps
module tb_fbud_ctrl;

  localparam int TOTAL  = 256;
  localparam int DW     = 8;
  localparam int MAXC   = 32;
  localparam int CW     = $clog2(MAXC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_mode_in = '0;
  logic [DW-1:0] cfg_depth_in = '0;
  logic [1:0]    cfg_mode;
  logic [DW-1:0] cfg_depth;
  logic          act_valid = 1'b0;
  logic          act_hi = 1'b0;
  logic [DW-1:0] act_burst = '0;
  logic          rel_valid = 1'b0;
  logic          rel_hi = 1'b0;
  logic          rsp_valid, rsp_grant, rsp_burst_err, rel_err;
  logic [CW-1:0] hi_active, lo_active;

  always #2 clk = ~clk;

  fbud_ctrl #(.TOTAL_ENTRIES(TOTAL), .DEPTH_W(DW), .MAX_CH(MAXC)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_mode_in(cfg_mode_in), .cfg_depth_in(cfg_depth_in),
    .cfg_mode(cfg_mode), .cfg_depth(cfg_depth),
    .act_valid(act_valid), .act_hi(act_hi), .act_burst(act_burst),
    .rel_valid(rel_valid), .rel_hi(rel_hi),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_burst_err(rsp_burst_err),
    .rel_err(rel_err), .hi_active(hi_active), .lo_active(lo_active)
  );

  int n_total = 0;
  int n_bad   = 0;
  int cyc     = 0;
  bit done    = 0;

  // reference model state
  int m_mode  = 0;
  int m_depth = 16;
  int m_cnt [2] = '{0, 0};

  function automatic int class_budget(int mode, bit hi);
    case (mode)
      1: return hi ? TOTAL / 4 : (TOTAL * 3) / 4;
      2: return hi ? (TOTAL * 3) / 4 : TOTAL / 4;
      3: return TOTAL / 2;
      default: return TOTAL;
    endcase
  endfunction

  function automatic string mode_tag(int mode);
    case (mode)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // One cycle: drive at negedge, predict, sample at next negedge.
  task automatic step(input bit cw, input int cm, input int cd,
                      input bit av, input bit ah, input int ab,
                      input bit rv, input bit rh);
    bit e_rel_err, e_grant, e_berr;
    string tag;
    int occ, need;
    cfg_wr = cw; cfg_mode_in = cm[1:0]; cfg_depth_in = cd[DW-1:0];
    act_valid = av; act_hi = ah; act_burst = ab[DW-1:0];
    rel_valid = rv; rel_hi = rh;
    e_rel_err = 0; e_grant = 0; e_berr = 0; tag = "R9";
    if (rv) begin
      if (m_cnt[rh] == 0) e_rel_err = 1;
      else m_cnt[rh]--;
    end
    if (av) begin
      if (ab >= m_depth) begin
        e_berr = 1; tag = "R8";
      end else if (m_cnt[ah] == MAXC) begin
        tag = "R12";
      end else begin
        occ  = (m_mode == 0) ? m_cnt[0] + m_cnt[1] : m_cnt[ah];
        need = (occ + 1) * (m_depth + 1);
        e_grant = (need <= class_budget(m_mode, ah));
        tag = (rv && rh == ah) ? "R11" : mode_tag(m_mode);
        if (e_grant) m_cnt[ah]++;
      end
    end
    if (cw) begin
      m_mode = cm;
      if (cd != 0) m_depth = cd;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rsp_valid"}, rsp_valid, av);
    chk({tag, " grant R3"}, rsp_grant, e_grant);
    chk("R8 burst_err", rsp_burst_err, e_berr);
    chk("R10 rel_err", rel_err, e_rel_err);
    chk("R9 hi_active", hi_active, m_cnt[1]);
    chk("R9 lo_active", lo_active, m_cnt[0]);
    chk("R2 mode", cfg_mode, m_mode);
    chk("R2 depth", cfg_depth, m_depth);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    while (m_cnt[1] > 0) step(0, 0, 0, 0, 0, 0, 1, 1);
    while (m_cnt[0] > 0) step(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 depth", cfg_depth, 16);
    chk("R1 mode", cfg_mode, 0);
    chk("R1 hi_active", hi_active, 0);
    chk("R1 lo_active", lo_active, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rel_err", rel_err, 0);

    // R2: depth 0 write ignored, mode loaded
    step(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 depth kept", cfg_depth, 16);
    chk("R2 mode 1", cfg_mode, 1);

    // R5: high budget 64 with charge 17 -> 3 grants, 4th denied
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, 4, 0, 0);
    chk("R5 hi full", hi_active, 3);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 0, 4, 0, 0);
    chk("R5 lo full", lo_active, 11);

    // R11: release and activate together while full
    step(0, 0, 0, 1, 1, 4, 1, 1);
    chk("R11 swap", hi_active, 3);

    // R10: release past empty
    drain();
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);

    // R8: burst boundary
    step(0, 0, 0, 1, 1, 16, 0, 0);
    step(0, 0, 0, 1, 1, 15, 0, 0);
    step(0, 0, 0, 1, 0, 200, 0, 0);

    // R6, R7, R4 fill each class
    for (int md = 2; md <= 4; md++) begin
      drain();
      step(1, md % 4, 31, 0, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, i[0], 8, 0, 0);
    end

    // R12: cap with depth 1 in pooled mode
    drain();
    step(1, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < MAXC + 2; i++) step(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R12 cap", hi_active, MAXC);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit cw = ($urandom_range(0, 29) == 0);
      int cm = $urandom_range(0, 3);
      int cd = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 24);
      bit av = ($urandom_range(0, 9) < 6);
      bit ah = $urandom_range(0, 1);
      int ab = $urandom_range(0, 28);
      bit rv = ($urandom_range(0, 9) < 4);
      bit rh = $urandom_range(0, 1);
      step(cw, cm, cd, av, ah, ab, rv, rh);
    end
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule